// File: doc/BRIEF.md
# Interrupt Acknowledge and Running-Priority Unit

This block is the part of a multi-CPU interrupt controller's CPU interface that takes interrupts into service and lets them go again. Each CPU has a selector result, the ID of its most urgent candidate, which comes from outside. When a CPU issues an acknowledge, the unit checks that ID against that CPU's view of the pending state. If the ID is pending, the unit returns it, marks it in service (active) and clears its pending bit. If it is not, the unit returns the spurious ID 1023. An end-of-interrupt names a CPU and an ID. It clears that ID's active bit, or raises a warning pulse when the ID was not active.

The unit keeps the pending, active and priority arrays. IDs 0 to 31 are banked, so each CPU has its own pending bit, active bit and priority byte for them. IDs 32 and above are shared by all CPUs. Every accepted acknowledge or end-of-interrupt starts a sequential scan. The scan recomputes each CPU's running priority, which is the smallest priority value among the interrupts that CPU sees as active. While the scan runs, the unit holds off new acknowledge and end-of-interrupt requests, so a CPU never acknowledges against a stale running priority. A CPU whose interface is disabled keeps its previous running priority through a scan.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset, every run_prio_o lane is 0xFF and ready_o is 1. ack_done_o and eoi_warn_o are 0. No ID is pending or active, and every priority byte is 0.
- R2: An acknowledge is accepted when ack_valid_i and ready_o are both high. If the selected ID hp_id_i[ack_cpu_i] is pending in that CPU's view, then in the next cycle ack_done_o pulses and ack_id_o carries that ID. The ID becomes active and is no longer pending, so a repeated acknowledge returns 1023.
- R3: An accepted acknowledge whose selected ID is 1023, is NUM_IRQ or above, or is not pending in the requesting CPU's view returns ack_id_o = 1023 and changes no pending or active bit.
- R4: An accepted end-of-interrupt for an ID that is active in eoi_cpu_i's view clears that active bit, and the running priority then drops that ID.
- R5: An accepted end-of-interrupt for an ID that is not active, or that is NUM_IRQ or above, produces a one-cycle eoi_warn_o pulse in the next cycle and changes no state.
- R6: After a scan, run_prio_o[c] is the smallest priority value among the IDs active for CPU c, and 0xFF when none is active. A lower value is more urgent. For IDs 0 to 31 the scan uses CPU c's own active bits and its own banked priorities. For IDs 32 and above it uses the shared active bits and shared priorities, and these count for every CPU.
- R7: Every accepted acknowledge or end-of-interrupt starts a recompute. ready_o stays low for exactly NUM_IRQ/SCAN_LANES cycles. Requests presented while ready_o is low are ignored: they produce no response and no state change.
- R8: A CPU whose cpu_en_i bit is low when a scan finishes keeps its previous run_prio_o value.
- R9: A priority write to an ID below 32 changes only the copy of the CPU named by prio_wr_cpu_i. A write to ID 32 or above changes the single shared byte.
- R10: A pending-set strobe sets the pending bit of pset_id_i. For IDs below 32 it sets the bit in the bank of pset_cpu_i only. For IDs 32 and above it sets the shared bit, and pset_cpu_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_en_i | input | NUM_CPUS | Per-CPU interface enable |
| hp_id_i | input | NUM_CPUS x 10 | Selector result per CPU, 1023 for none |
| pset_valid_i | input | 1 | Pending-set strobe |
| pset_cpu_i | input | CPU_W | CPU bank for a banked pending set |
| pset_id_i | input | 10 | ID to mark pending |
| prio_wr_valid_i | input | 1 | Priority write strobe |
| prio_wr_cpu_i | input | CPU_W | CPU bank for a banked priority write |
| prio_wr_id_i | input | 10 | ID whose priority is written |
| prio_wr_data_i | input | 8 | Priority value, lower is more urgent |
| ack_valid_i | input | 1 | Acknowledge request |
| ack_cpu_i | input | CPU_W | Acknowledging CPU |
| eoi_valid_i | input | 1 | End-of-interrupt request |
| eoi_cpu_i | input | CPU_W | CPU completing the interrupt |
| eoi_id_i | input | 10 | ID being completed |
| ready_o | output | 1 | High when no recompute is in progress |
| ack_done_o | output | 1 | Acknowledge response valid |
| ack_id_o | output | 10 | Acknowledged ID or 1023 |
| eoi_warn_o | output | 1 | End-of-interrupt named an inactive ID |
| run_prio_o | output | NUM_CPUS x 8 | Running priority per CPU |

## Verification
The inline assertions check the handshake rules on every cycle. A response follows only an accepted request, ready_o falls after every acceptance, running priorities do not move in the middle of a scan, and a disabled CPU's running priority stays frozen. Some behaviours only the bench scenarios can show. These are the returned IDs, which bits become active or stay pending, the banked-versus-shared priority selection, and the minimum taken over several overlapping active interrupts. For that purpose the bench sweeps every ID on every CPU and checks each result against values it computes itself.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int ID_W     = 10;
  localparam int PRIO_W   = 8;
  localparam int BANKED_N = 32;
  localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] PRIO_IDLE   = 8'hFF;
endpackage

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_ack_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_IRQ  = 64,
  parameter int CPU_W    = 1
) (
  input  logic                                             clk_i,
  input  logic                                             rst_ni,
  input  logic                                             pset_valid_i,
  input  logic [CPU_W-1:0]                                 pset_cpu_i,
  input  logic [ID_W-1:0]                                  pset_id_i,
  input  logic                                             prio_wr_valid_i,
  input  logic [CPU_W-1:0]                                 prio_wr_cpu_i,
  input  logic [ID_W-1:0]                                  prio_wr_id_i,
  input  logic [PRIO_W-1:0]                                prio_wr_data_i,
  input  logic                                             ack_fire_i,
  input  logic [CPU_W-1:0]                                 ack_cpu_i,
  input  logic [ID_W-1:0]                                  ack_id_i,
  input  logic                                             eoi_fire_i,
  input  logic [CPU_W-1:0]                                 eoi_cpu_i,
  input  logic [ID_W-1:0]                                  eoi_id_i,
  output logic                                             ack_hit_o,
  output logic                                             eoi_hit_o,
  output logic [NUM_CPUS-1:0][NUM_IRQ-1:0]                 act_o,
  output logic [NUM_CPUS-1:0][NUM_IRQ-1:0][PRIO_W-1:0]     prio_o
);
  localparam int NSH  = NUM_IRQ - BANKED_N;
  localparam int SH_W = (NSH > 1) ? $clog2(NSH) : 1;
  localparam int BK_W = $clog2(BANKED_N);

  logic [NUM_CPUS-1:0][BANKED_N-1:0]             bpend_q, bact_q;
  logic [NUM_CPUS-1:0][BANKED_N-1:0][PRIO_W-1:0] bprio_q;
  logic [NSH-1:0]                                spend_q, sact_q;
  logic [NSH-1:0][PRIO_W-1:0]                    sprio_q;

  function automatic logic in_range(logic [ID_W-1:0] id);
    return id < ID_W'(NUM_IRQ);
  endfunction

  function automatic logic is_banked(logic [ID_W-1:0] id);
    return id < ID_W'(BANKED_N);
  endfunction

  function automatic logic [SH_W-1:0] sh_idx(logic [ID_W-1:0] id);
    logic [ID_W-1:0] d;
    d = id - ID_W'(BANKED_N);
    return d[SH_W-1:0];
  endfunction

  always_comb begin
    ack_hit_o = 1'b0;
    if (in_range(ack_id_i))
      ack_hit_o = is_banked(ack_id_i) ? bpend_q[ack_cpu_i][ack_id_i[BK_W-1:0]]
                                      : spend_q[sh_idx(ack_id_i)];
    eoi_hit_o = 1'b0;
    if (in_range(eoi_id_i))
      eoi_hit_o = is_banked(eoi_id_i) ? bact_q[eoi_cpu_i][eoi_id_i[BK_W-1:0]]
                                      : sact_q[sh_idx(eoi_id_i)];
  end

  // Later assignments win: pending set before ack clear, EOI clear before ack set.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bpend_q <= '0;
      bact_q  <= '0;
      spend_q <= '0;
      sact_q  <= '0;
    end else begin
      if (pset_valid_i && in_range(pset_id_i)) begin
        if (is_banked(pset_id_i)) bpend_q[pset_cpu_i][pset_id_i[BK_W-1:0]] <= 1'b1;
        else                      spend_q[sh_idx(pset_id_i)]               <= 1'b1;
      end
      if (eoi_fire_i && eoi_hit_o) begin
        if (is_banked(eoi_id_i)) bact_q[eoi_cpu_i][eoi_id_i[BK_W-1:0]] <= 1'b0;
        else                     sact_q[sh_idx(eoi_id_i)]              <= 1'b0;
      end
      if (ack_fire_i && ack_hit_o) begin
        if (is_banked(ack_id_i)) begin
          bact_q[ack_cpu_i][ack_id_i[BK_W-1:0]]  <= 1'b1;
          bpend_q[ack_cpu_i][ack_id_i[BK_W-1:0]] <= 1'b0;
        end else begin
          sact_q[sh_idx(ack_id_i)]  <= 1'b1;
          spend_q[sh_idx(ack_id_i)] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bprio_q <= '0;
      sprio_q <= '0;
    end else if (prio_wr_valid_i && in_range(prio_wr_id_i)) begin
      if (is_banked(prio_wr_id_i))
        bprio_q[prio_wr_cpu_i][prio_wr_id_i[BK_W-1:0]] <= prio_wr_data_i;
      else
        sprio_q[sh_idx(prio_wr_id_i)] <= prio_wr_data_i;
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
      if (i < BANKED_N) begin : g_bank
        assign act_o[c][i]  = bact_q[c][i];
        assign prio_o[c][i] = bprio_q[c][i];
      end else begin : g_shared
        assign act_o[c][i]  = sact_q[i-BANKED_N];
        assign prio_o[c][i] = sprio_q[i-BANKED_N];
      end
    end
  end

  // R3: a miss leaves the active bits untouched when no EOI shares the cycle
  p_miss_no_change_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire_i && !ack_hit_o && !eoi_fire_i) |=> $stable(act_o));
endmodule

// File: rtl/irq_runprio_scan.sv
module irq_runprio_scan
  import irq_ack_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_IRQ  = 64,
  parameter int LANES    = 4
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         start_i,
  input  logic [NUM_CPUS-1:0]                          cpu_en_i,
  input  logic [NUM_CPUS-1:0][NUM_IRQ-1:0]             act_i,
  input  logic [NUM_CPUS-1:0][NUM_IRQ-1:0][PRIO_W-1:0] prio_i,
  output logic                                         busy_o,
  output logic [NUM_CPUS-1:0][PRIO_W-1:0]              run_prio_o
);
  localparam int CHUNKS = NUM_IRQ / LANES;
  localparam int IDX_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHUNKS - 1);

  logic                              busy_q;
  logic [IDX_W-1:0]                  idx_q;
  logic [NUM_CPUS-1:0][PRIO_W-1:0]   acc_q, cand, run_prio_q;

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      cand[c] = acc_q[c];
      for (int l = 0; l < LANES; l++) begin
        if (act_i[c][int'(idx_q)*LANES + l] &&
            prio_i[c][int'(idx_q)*LANES + l] < cand[c])
          cand[c] = prio_i[c][int'(idx_q)*LANES + l];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      idx_q      <= '0;
      acc_q      <= {NUM_CPUS{PRIO_IDLE}};
      run_prio_q <= {NUM_CPUS{PRIO_IDLE}};
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      acc_q  <= {NUM_CPUS{PRIO_IDLE}};
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        for (int c = 0; c < NUM_CPUS; c++)
          if (cpu_en_i[c]) run_prio_q[c] <= cand[c];
      end else begin
        idx_q <= idx_q + 1'b1;
        acc_q <= cand;
      end
    end
  end

  assign busy_o     = busy_q;
  assign run_prio_o = run_prio_q;

  p_scan_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q != LAST) |=> ($stable(run_prio_q) && busy_q));
  p_start_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_ack_pkg::*;
#(
  parameter int NUM_CPUS   = 2,
  parameter int NUM_IRQ    = 64,
  parameter int SCAN_LANES = 4,
  localparam int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CPUS-1:0]              cpu_en_i,
  input  logic [NUM_CPUS-1:0][ID_W-1:0]    hp_id_i,
  input  logic                             pset_valid_i,
  input  logic [CPU_W-1:0]                 pset_cpu_i,
  input  logic [ID_W-1:0]                  pset_id_i,
  input  logic                             prio_wr_valid_i,
  input  logic [CPU_W-1:0]                 prio_wr_cpu_i,
  input  logic [ID_W-1:0]                  prio_wr_id_i,
  input  logic [PRIO_W-1:0]                prio_wr_data_i,
  input  logic                             ack_valid_i,
  input  logic [CPU_W-1:0]                 ack_cpu_i,
  input  logic                             eoi_valid_i,
  input  logic [CPU_W-1:0]                 eoi_cpu_i,
  input  logic [ID_W-1:0]                  eoi_id_i,
  output logic                             ready_o,
  output logic                             ack_done_o,
  output logic [ID_W-1:0]                  ack_id_o,
  output logic                             eoi_warn_o,
  output logic [NUM_CPUS-1:0][PRIO_W-1:0]  run_prio_o
);
  logic busy, ack_fire, eoi_fire, ack_hit, eoi_hit;
  logic [ID_W-1:0] sel_id;
  logic [NUM_CPUS-1:0][NUM_IRQ-1:0]             act;
  logic [NUM_CPUS-1:0][NUM_IRQ-1:0][PRIO_W-1:0] prio;
  logic ack_done_q, eoi_warn_q;
  logic [ID_W-1:0] ack_id_q;

  assign ready_o  = !busy;
  assign ack_fire = ack_valid_i && ready_o;
  assign eoi_fire = eoi_valid_i && ready_o;
  assign sel_id   = hp_id_i[ack_cpu_i];

  irq_state_bank #(
    .NUM_CPUS(NUM_CPUS), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W)
  ) u_bank (
    .clk_i, .rst_ni,
    .pset_valid_i, .pset_cpu_i, .pset_id_i,
    .prio_wr_valid_i, .prio_wr_cpu_i, .prio_wr_id_i, .prio_wr_data_i,
    .ack_fire_i (ack_fire),
    .ack_cpu_i  (ack_cpu_i),
    .ack_id_i   (sel_id),
    .eoi_fire_i (eoi_fire),
    .eoi_cpu_i  (eoi_cpu_i),
    .eoi_id_i   (eoi_id_i),
    .ack_hit_o  (ack_hit),
    .eoi_hit_o  (eoi_hit),
    .act_o      (act),
    .prio_o     (prio)
  );

  irq_runprio_scan #(
    .NUM_CPUS(NUM_CPUS), .NUM_IRQ(NUM_IRQ), .LANES(SCAN_LANES)
  ) u_scan (
    .clk_i, .rst_ni,
    .start_i    (ack_fire || eoi_fire),
    .cpu_en_i   (cpu_en_i),
    .act_i      (act),
    .prio_i     (prio),
    .busy_o     (busy),
    .run_prio_o (run_prio_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_done_q <= 1'b0;
      ack_id_q   <= SPURIOUS_ID;
      eoi_warn_q <= 1'b0;
    end else begin
      ack_done_q <= ack_fire;
      eoi_warn_q <= eoi_fire && !eoi_hit;
      if (ack_fire) ack_id_q <= ack_hit ? sel_id : SPURIOUS_ID;
    end
  end

  assign ack_done_o = ack_done_q;
  assign ack_id_o   = ack_id_q;
  assign eoi_warn_o = eoi_warn_q;

  p_ack_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_done_o |-> $past(ack_valid_i && ready_o));
  p_warn_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_warn_o |-> $past(eoi_valid_i && ready_o));
  p_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ack_valid_i || eoi_valid_i) && ready_o) |=> !ready_o);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
    p_off_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cpu_en_i[c] |=> $stable(run_prio_o[c]));
  end
endmodule

// File: tb/irq_ack_unit_tb_top.sv
module irq_ack_unit_tb_top;
  localparam int NC = 2, NI = 64, LN = 4, CHUNKS = NI / LN;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] cpu_en_i = 2'b11;
  logic [1:0][9:0] hp_id_i = {10'd1023, 10'd1023};
  logic pset_valid_i = 0, prio_wr_valid_i = 0, ack_valid_i = 0, eoi_valid_i = 0;
  logic pset_cpu_i = 0, prio_wr_cpu_i = 0, ack_cpu_i = 0, eoi_cpu_i = 0;
  logic [9:0] pset_id_i = '0, prio_wr_id_i = '0, eoi_id_i = '0;
  logic [7:0] prio_wr_data_i = '0;
  logic ready_o, ack_done_o, eoi_warn_o;
  logic [9:0] ack_id_o;
  logic [1:0][7:0] run_prio_o;

  int n_tests = 0, n_fail = 0;
  bit mact [NC][NI];
  int rp_m [NC];

  always #5 clk_i = ~clk_i;

  irq_ack_unit #(.NUM_CPUS(NC), .NUM_IRQ(NI), .SCAN_LANES(LN)) dut_i (.*);

  task automatic check(input string req, input string what, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  function automatic int pr(input int c, input int i);
    return (i < 32) ? (i * 5 + c * 3 + 16) : ((i - 32) * 7 + 20);
  endfunction

  function automatic int exp_min(input int c);
    int m = 255;
    for (int i = 0; i < NI; i++) begin
      bit a = (i < 32) ? mact[c][i] : mact[0][i];
      if (a && pr(c, i) < m) m = pr(c, i);
    end
    return m;
  endfunction

  task automatic update_rp();
    for (int c = 0; c < NC; c++) if (cpu_en_i[c]) rp_m[c] = exp_min(c);
  endtask

  task automatic check_rp(input string req);
    for (int c = 0; c < NC; c++) check(req, $sformatf("run_prio[%0d]", c), run_prio_o[c], rp_m[c]);
  endtask

  task automatic wait_ready(input int exp_low);
    int n = 0;
    while (!ready_o) begin n++; @(negedge clk_i); end
    if (exp_low >= 0) check("R7", "ready low cycles", n, exp_low);
  endtask

  task automatic write_prio(input int c, input int id, input int d);
    @(negedge clk_i);
    prio_wr_valid_i = 1; prio_wr_cpu_i = 1'(c); prio_wr_id_i = 10'(id); prio_wr_data_i = 8'(d);
    @(negedge clk_i);
    prio_wr_valid_i = 0;
  endtask

  task automatic set_pend(input int c, input int id);
    @(negedge clk_i);
    pset_valid_i = 1; pset_cpu_i = 1'(c); pset_id_i = 10'(id);
    @(negedge clk_i);
    pset_valid_i = 0;
  endtask

  task automatic do_ack(input int c, input int exp_id, input string req);
    @(negedge clk_i);
    ack_valid_i = 1; ack_cpu_i = 1'(c);
    @(negedge clk_i);
    ack_valid_i = 0;
    check(req, "ack_done", ack_done_o, 1);
    check(req, "ack_id", ack_id_o, exp_id);
    if (exp_id != 1023) mact[(exp_id < 32) ? c : 0][exp_id] = 1'b1;
    wait_ready(CHUNKS);
    update_rp();
    check_rp("R6");
  endtask

  task automatic do_eoi(input int c, input int id, input int exp_warn, input string req);
    @(negedge clk_i);
    eoi_valid_i = 1; eoi_cpu_i = 1'(c); eoi_id_i = 10'(id);
    @(negedge clk_i);
    eoi_valid_i = 0;
    check(req, "eoi_warn", eoi_warn_o, exp_warn);
    if (exp_warn == 0) mact[(id < 32) ? c : 0][id] = 1'b0;
    wait_ready(CHUNKS);
    update_rp();
    check_rp(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) rp_m[c] = 255;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check("R1", "ready", ready_o, 1);
    check("R1", "ack_done", ack_done_o, 0);
    check("R1", "eoi_warn", eoi_warn_o, 0);
    check_rp("R1");
    // R1 priorities reset to zero
    set_pend(0, 33); hp_id_i[0] = 10'd33;
    @(negedge clk_i); ack_valid_i = 1; ack_cpu_i = 0;
    @(negedge clk_i); ack_valid_i = 0;
    check("R1", "ack_id", ack_id_o, 33);
    wait_ready(CHUNKS);
    check("R1", "run_prio zero prio", run_prio_o[0], 0);
    check("R1", "run_prio shared other cpu", run_prio_o[1], 0);
    @(negedge clk_i); eoi_valid_i = 1; eoi_cpu_i = 0; eoi_id_i = 10'd33;
    @(negedge clk_i); eoi_valid_i = 0;
    wait_ready(CHUNKS);
    check_rp("R4");

    // R9 program banked per cpu and shared priorities
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < 32; i++) write_prio(c, i, pr(c, i));
    for (int i = 32; i < NI; i++) write_prio(1, i, pr(0, i));

    // sweep every ID on every CPU: R2 R3 R4 R5 R6 R9 R10
    for (int c = 0; c < NC; c++) begin
      for (int id = 0; id < NI; id++) begin
        set_pend(c, id);
        hp_id_i[c] = 10'(id);
        do_ack(c, id, "R2");
        do_ack(c, 1023, "R3");
        do_eoi(c, id, 0, "R4");
        do_eoi(c, id, 1, "R5");
      end
    end

    // R3 spurious selector and out-of-range ID
    hp_id_i[0] = 10'd1023; do_ack(0, 1023, "R3");
    hp_id_i[0] = 10'd100;  do_ack(0, 1023, "R3");
    do_eoi(0, 100, 1, "R5");

    // R10 banked pending is per CPU
    set_pend(1, 20); hp_id_i[0] = 10'd20;
    do_ack(0, 1023, "R10");
    hp_id_i[1] = 10'd20; do_ack(1, 20, "R10");
    do_eoi(1, 20, 0, "R4");

    // R6 minimum across several active interrupts
    begin
      int ids[4] = '{40, 7, 50, 3};
      int eo[4]  = '{3, 40, 7, 50};
      for (int k = 0; k < 4; k++) begin
        set_pend(0, ids[k]); hp_id_i[0] = 10'(ids[k]);
        do_ack(0, ids[k], "R6");
      end
      for (int k = 0; k < 4; k++) do_eoi(0, eo[k], 0, "R6");
    end

    // R7 requests during a scan are ignored
    set_pend(0, 12); hp_id_i[0] = 10'd12;
    do_eoi(0, 13, 1, "R5");
    @(negedge clk_i); eoi_valid_i = 1; eoi_cpu_i = 0; eoi_id_i = 10'd13;
    @(negedge clk_i); eoi_valid_i = 0;
    check("R5", "eoi_warn", eoi_warn_o, 1);
    for (int k = 0; k < 3; k++) begin
      ack_valid_i = 1; ack_cpu_i = 0; eoi_valid_i = 1; eoi_id_i = 10'd14;
      @(negedge clk_i);
      check("R7", "ack_done while busy", ack_done_o, 0);
      check("R7", "eoi_warn while busy", eoi_warn_o, 0);
    end
    ack_valid_i = 0; eoi_valid_i = 0;
    wait_ready(-1);
    @(negedge clk_i);
    check("R7", "ack_done after stall", ack_done_o, 0);
    do_ack(0, 12, "R7");
    do_eoi(0, 12, 0, "R4");

    // R8 disabled CPU keeps its running priority
    cpu_en_i = 2'b01;
    set_pend(1, 9); hp_id_i[1] = 10'd9;
    do_ack(1, 9, "R8");
    check("R8", "run_prio[1] frozen", run_prio_o[1], 255);
    cpu_en_i = 2'b11;
    do_eoi(0, 60, 1, "R8");
    check("R8", "run_prio[1] after enable", run_prio_o[1], pr(1, 9));
    do_eoi(1, 9, 0, "R4");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule